// File: doc/BRIEF.md
# Bus Takeover and Mailbox Controller

This block runs next to an 8-bit processor and shares the processor's memory bus with it. It can push the processor off the bus with a bus-enable line. It then drives the bus itself, but only the low eight address bits. The upper address lines are pulled high on the board, so every access the controller makes lands in the top page, $FF00 to $FFFF.

After reset the controller keeps the processor off the bus and in reset. It writes a boot image and the six vector bytes into the top page. It then steps off the bus, re-enables the processor, and finally lets it out of reset.

At run time the processor asks for service by halting on a wait-for-interrupt, which drives its ready output low. The controller sees this and takes the bus. After a fixed settling delay it works through host requests: mailbox writes, mailbox reads, and a release command. Host requests are held in a FIFO and run in order. Requests that arrive while the controller is idle are kept until the next takeover. Interrupt sources are held off the processor while it is halted or serviced. A release hands the bus back and ends with a single-cycle wake pulse on the interrupt line.

Top module: `bus_takeover_ctrl`

## Requirements
- R1: The controller drives the address and data lines only while `cpu_be_o` is low. It drives only eight address bits, so offset N reaches $FF00+N.
- R2: After reset, `cpu_be_o` and `cpu_rst_n_o` are low. The controller first writes boot byte k = (7*k + 0x3C) mod 256 at offsets k = 0 to BOOT_LEN-1. It then writes the vector bytes at offsets 0xFA to 0xFF, with 0x00 at even offsets and 0xFF at odd offsets. Next it tri-states its drivers, then raises `cpu_be_o`, and raises `cpu_rst_n_o` one cycle after that.
- R3: When the controller is idle and samples `cpu_rdy_i` low, it drives `cpu_be_o` low in the following cycle.
- R4: No bus access happens until `cpu_be_o` has been low for at least DELAY cycles.
- R5: A host request is served during a takeover. Op 0 writes data to the given offset. Op 1 reads the given offset and returns the byte on `hrsp_data_o`, with a one-cycle `hrsp_valid_o`.
- R6: During run-time service, a write whose offset is 0x90 or higher performs no write cycle, and the memory there keeps its old value.
- R7: `cpu_irq_o` follows `irq_src_i` only while `cpu_rdy_i` is high and the controller is idle. At all other times `irq_src_i` is blocked.
- R8: Op 2 (release) ends the service in this order: tri-state the drivers; one cycle later raise `cpu_be_o`; then give exactly one cycle of `cpu_irq_o`. The controller does not take the bus again until `cpu_rdy_i` has returned high.
- R9: Requests are queued whenever they arrive, including while the controller is idle or in the middle of a transfer. They are executed in arrival order. `hreq_full_o` is high while FIFO_DEPTH requests are waiting.
- R10: `busy_o` is high exactly while the controller holds `cpu_be_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rdy_i | input | 1 | Processor ready output; low means halted and asking for service |
| irq_src_i | input | 1 | Level interrupt request from the system |
| cpu_be_o | output | 1 | Processor bus enable; low isolates the processor |
| cpu_rst_n_o | output | 1 | Processor reset, active low |
| cpu_irq_o | output | 1 | Gated interrupt to the processor, also carries the wake pulse |
| bus_addr_o | output | 8 | Low address byte driven during takeover |
| bus_addr_oe_o | output | 1 | Address driver enable |
| bus_rw_o | output | 1 | Read/write line, 1 = read, 0 = write |
| bus_data_o | output | 8 | Write data |
| bus_data_oe_o | output | 1 | Data driver enable |
| bus_data_i | input | 8 | Read data from memory |
| hreq_valid_i | input | 1 | Host request strobe |
| hreq_op_i | input | 2 | 0 = write, 1 = read, 2 = release |
| hreq_off_i | input | 8 | Offset within the top page |
| hreq_data_i | input | 8 | Write data |
| hreq_full_o | output | 1 | Request FIFO full |
| hrsp_valid_o | output | 1 | Read response strobe |
| hrsp_data_o | output | 8 | Read response byte |
| busy_o | output | 1 | Controller owns the bus |

## Verification
The assertions check several rules on every cycle:
- The drivers are never enabled while bus-enable is high.
- Bus accesses respect the settling delay.
- Bus-enable rises only after the drivers are off.
- Reset rises only after bus-enable.
- Run-time writes never touch offsets at 0x90 and above.
- An interrupt reaches a halted processor only as a wake pulse after release.

Other properties need memory contents or request history, so only the bench scenarios can show them. These are the boot image contents, read-back data from the mailbox, the arrival-order execution of queued requests, and the survival of bytes that a protected write failed to change.

// File: rtl/tko_pkg.sv
package tko_pkg;

    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_RD  = 2'd1,
        OP_REL = 2'd2,
        OP_NOP = 2'd3
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [7:0] off;
        logic [7:0] data;
    } req_t;

    typedef enum logic [3:0] {
        S_BHOLD, S_BWR, S_BDET, S_BBE,
        S_RUN, S_TAKE, S_SERVE, S_EXEC,
        S_RDET, S_RBE, S_WAKE, S_WRDY
    } st_e;

    typedef struct packed {
        logic       be;
        logic       rst_n;
        logic       addr_oe;
        logic       data_oe;
        logic       rw;
        logic [7:0] addr;
        logic [7:0] data;
    } drv_t;

    localparam int NUM_VEC = 6;
    localparam logic [7:0] VEC_BASE = 8'hFA;

    function automatic logic [7:0] boot_byte(input logic [7:0] k);
        return k * 8'd7 + 8'h3C;
    endfunction

    function automatic logic [7:0] vec_byte(input logic [7:0] j);
        return j[0] ? 8'hFF : 8'h00;
    endfunction

endpackage

// File: rtl/tko_req_fifo.sv
module tko_req_fifo
    import tko_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  req_t din,
    input  logic pop,
    output req_t dout,
    output logic empty,
    output logic full
);
    localparam int AW = $clog2(DEPTH);

    req_t mem [DEPTH];
    logic [AW:0] wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign dout  = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) begin
                mem[wp[AW-1:0]] <= din;
                wp <= wp + 1'b1;
            end
            if (pop && !empty) begin
                rp <= rp + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tko_seq.sv
module tko_seq
    import tko_pkg::*;
#(
    parameter int DELAY    = 4,
    parameter int BOOT_LEN = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rdy,
    input  logic       q_empty,
    input  req_t       q_head,
    input  logic [7:0] rdata,
    output logic       q_pop,
    output st_e        st,
    output req_t       cur,
    output logic [7:0] bidx,
    output logic       rsp_valid,
    output logic [7:0] rsp_data
);
    localparam int CW    = $clog2(DELAY + 1);
    localparam int TOTAL = BOOT_LEN + NUM_VEC;

    logic [CW-1:0] cnt;

    assign q_pop = (st == S_SERVE) && !q_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_BHOLD;
            cnt       <= '0;
            bidx      <= '0;
            cur       <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st)
                S_BHOLD: begin
                    if (cnt == CW'(DELAY - 1)) begin
                        cnt <= '0;
                        st  <= S_BWR;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_BWR: begin
                    if (bidx == 8'(TOTAL - 1)) st <= S_BDET;
                    else                       bidx <= bidx + 1'b1;
                end
                S_BDET: st <= S_BBE;
                S_BBE:  st <= S_RUN;
                S_RUN:  if (!rdy) st <= S_TAKE;
                S_TAKE: begin
                    if (cnt == CW'(DELAY - 1)) begin
                        cnt <= '0;
                        st  <= S_SERVE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_SERVE: begin
                    if (!q_empty) begin
                        if (q_head.op == OP_REL) begin
                            st <= S_RDET;
                        end else begin
                            cur <= q_head;
                            st  <= S_EXEC;
                        end
                    end
                end
                S_EXEC: begin
                    if (cur.op == OP_RD) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= rdata;
                    end
                    st <= S_SERVE;
                end
                S_RDET: st <= S_RBE;
                S_RBE:  st <= S_WAKE;
                S_WAKE: st <= S_WRDY;
                S_WRDY: if (rdy) st <= S_RUN;
                default: st <= S_RUN;
            endcase
        end
    end
endmodule

// File: rtl/tko_bus_mux.sv
module tko_bus_mux
    import tko_pkg::*;
#(
    parameter int         BOOT_LEN  = 200,
    parameter logic [7:0] PROT_BASE = 8'h90
) (
    input  st_e        st,
    input  req_t       cur,
    input  logic [7:0] bidx,
    output drv_t       drv
);
    logic [7:0] vj;
    logic       wr_ok;

    assign vj    = bidx - 8'(BOOT_LEN);
    assign wr_ok = (cur.op == OP_WR) && (cur.off < PROT_BASE);

    always_comb begin
        drv = '{be: 1'b1, rst_n: 1'b1, addr_oe: 1'b0, data_oe: 1'b0,
                rw: 1'b1, addr: 8'h00, data: 8'h00};
        unique case (st)
            S_BHOLD, S_BDET: begin
                drv.be    = 1'b0;
                drv.rst_n = 1'b0;
            end
            S_BWR: begin
                drv.be      = 1'b0;
                drv.rst_n   = 1'b0;
                drv.addr_oe = 1'b1;
                drv.data_oe = 1'b1;
                drv.rw      = 1'b0;
                if (bidx < 8'(BOOT_LEN)) begin
                    drv.addr = bidx;
                    drv.data = boot_byte(bidx);
                end else begin
                    drv.addr = VEC_BASE + vj;
                    drv.data = vec_byte(vj);
                end
            end
            S_BBE: drv.rst_n = 1'b0;
            S_TAKE, S_SERVE, S_RDET: drv.be = 1'b0;
            S_EXEC: begin
                drv.be      = 1'b0;
                drv.addr_oe = 1'b1;
                drv.addr    = cur.off;
                drv.data_oe = wr_ok;
                drv.rw      = !wr_ok;
                drv.data    = cur.data;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_takeover_ctrl.sv
module bus_takeover_ctrl
    import tko_pkg::*;
#(
    parameter int         DELAY      = 4,
    parameter int         BOOT_LEN   = 200,
    parameter int         FIFO_DEPTH = 8,
    parameter logic [7:0] PROT_BASE  = 8'h90
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_rdy_i,
    input  logic       irq_src_i,
    output logic       cpu_be_o,
    output logic       cpu_rst_n_o,
    output logic       cpu_irq_o,
    output logic [7:0] bus_addr_o,
    output logic       bus_addr_oe_o,
    output logic       bus_rw_o,
    output logic [7:0] bus_data_o,
    output logic       bus_data_oe_o,
    input  logic [7:0] bus_data_i,
    input  logic       hreq_valid_i,
    input  logic [1:0] hreq_op_i,
    input  logic [7:0] hreq_off_i,
    input  logic [7:0] hreq_data_i,
    output logic       hreq_full_o,
    output logic       hrsp_valid_o,
    output logic [7:0] hrsp_data_o,
    output logic       busy_o
);
    req_t       q_in, q_head, cur;
    logic       q_empty, q_full, q_pop;
    st_e        st;
    logic [7:0] bidx;
    drv_t       drv;

    assign q_in = '{op: op_e'(hreq_op_i), off: hreq_off_i, data: hreq_data_i};

    tko_req_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(hreq_valid_i), .din(q_in),
        .pop(q_pop), .dout(q_head),
        .empty(q_empty), .full(q_full)
    );

    tko_seq #(.DELAY(DELAY), .BOOT_LEN(BOOT_LEN)) u_seq (
        .clk(clk), .rst(rst), .rdy(cpu_rdy_i),
        .q_empty(q_empty), .q_head(q_head), .rdata(bus_data_i),
        .q_pop(q_pop), .st(st), .cur(cur), .bidx(bidx),
        .rsp_valid(hrsp_valid_o), .rsp_data(hrsp_data_o)
    );

    tko_bus_mux #(.BOOT_LEN(BOOT_LEN), .PROT_BASE(PROT_BASE)) u_mux (
        .st(st), .cur(cur), .bidx(bidx), .drv(drv)
    );

    assign cpu_be_o      = drv.be;
    assign cpu_rst_n_o   = drv.rst_n;
    assign bus_addr_o    = drv.addr;
    assign bus_addr_oe_o = drv.addr_oe;
    assign bus_rw_o      = drv.rw;
    assign bus_data_o    = drv.data;
    assign bus_data_oe_o = drv.data_oe;
    assign hreq_full_o   = q_full;
    assign busy_o        = !drv.be;

    // interrupts pass only while idle and awake; the wake pulse is the sole exception
    assign cpu_irq_o = (st == S_WAKE) || (irq_src_i && cpu_rdy_i && st == S_RUN);
endmodule

// File: rtl/tko_checker.sv
module tko_checker #(
    parameter int         DELAY     = 4,
    parameter logic [7:0] PROT_BASE = 8'h90
) (
    input logic       clk,
    input logic       rst,
    input logic       cpu_rdy_i,
    input logic       cpu_be_o,
    input logic       cpu_rst_n_o,
    input logic       cpu_irq_o,
    input logic [7:0] bus_addr_o,
    input logic       bus_addr_oe_o,
    input logic       bus_rw_o,
    input logic       bus_data_oe_o,
    input logic       busy_o
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || cpu_be_o) low_cnt <= '0;
        else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
    end

    a_r1_drive_only_isolated: assert property (@(posedge clk) disable iff (rst)
        (bus_addr_oe_o || bus_data_oe_o) |-> !cpu_be_o);

    a_r2_reset_after_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_rst_n_o) |-> (cpu_be_o && $past(cpu_be_o)));

    a_r4_settle_delay: assert property (@(posedge clk) disable iff (rst)
        bus_addr_oe_o |-> (low_cnt >= 16'(DELAY)));

    a_r6_protected_area: assert property (@(posedge clk) disable iff (rst)
        (cpu_rst_n_o && bus_data_oe_o && !bus_rw_o) |-> (bus_addr_o < PROT_BASE));

    a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq_o && !cpu_rdy_i) |-> (cpu_be_o && $past(cpu_be_o)));

    a_r8_enable_after_detach: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_be_o) |-> ($past(!bus_addr_oe_o) && $past(!bus_data_oe_o)));

    a_r10_busy_mirrors: assert property (@(posedge clk) disable iff (rst)
        busy_o != cpu_be_o);
endmodule

bind bus_takeover_ctrl tko_checker #(.DELAY(DELAY), .PROT_BASE(PROT_BASE)) i_chk (
    .clk(clk), .rst(rst), .cpu_rdy_i(cpu_rdy_i), .cpu_be_o(cpu_be_o),
    .cpu_rst_n_o(cpu_rst_n_o), .cpu_irq_o(cpu_irq_o), .bus_addr_o(bus_addr_o),
    .bus_addr_oe_o(bus_addr_oe_o), .bus_rw_o(bus_rw_o),
    .bus_data_oe_o(bus_data_oe_o), .busy_o(busy_o)
);

// File: tb/test_bus_takeover_ctrl.sv
`timescale 1ns/1ps
module test_bus_takeover_ctrl;
    localparam int DELAY = 4;
    localparam int BOOT_LEN = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_src = 1'b0;
    logic cpu_rdy;
    logic halt_req = 1'b0;
    logic be, rst_n, irq_o, aoe, rw, doe, full, rsp_v, busy;
    logic [7:0] addr, wdata, rdata, rsp_d;
    logic hv = 1'b0;
    logic [1:0] hop = '0;
    logic [7:0] hoff = '0, hdat = '0;

    int tests = 0, fails = 0, cyc = 0;
    logic [7:0] ram [256];
    logic [7:0] exp_q [$];

    always #10 clk = ~clk;

    bus_takeover_ctrl i_bus_takeover_ctrl (
        .clk(clk), .rst(rst), .cpu_rdy_i(cpu_rdy), .irq_src_i(irq_src),
        .cpu_be_o(be), .cpu_rst_n_o(rst_n), .cpu_irq_o(irq_o),
        .bus_addr_o(addr), .bus_addr_oe_o(aoe), .bus_rw_o(rw),
        .bus_data_o(wdata), .bus_data_oe_o(doe), .bus_data_i(rdata),
        .hreq_valid_i(hv), .hreq_op_i(hop), .hreq_off_i(hoff), .hreq_data_i(hdat),
        .hreq_full_o(full), .hrsp_valid_o(rsp_v), .hrsp_data_o(rsp_d), .busy_o(busy)
    );

    // top-page RAM; upper address lines are pulled high, so offset indexes $FF00+
    assign rdata = ram[addr];
    always_ff @(posedge clk) if (aoe && doe && !rw && !be) ram[addr] <= wdata;

    // processor model: halts on request, wakes on interrupt
    always_ff @(posedge clk) begin
        if (rst) cpu_rdy <= 1'b1;
        else if (halt_req) cpu_rdy <= 1'b0;
        else if (!cpu_rdy && irq_o) cpu_rdy <= 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_boot(input int k);
        return 8'((k * 7 + 'h3C) % 256);
    endfunction

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 60000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // monitor: scoreboard, ordering and delay rules
    logic p_be = 1'b0, p_rstn = 1'b0, p_aoe = 1'b0, p_doe = 1'b0, p_wake = 1'b0;
    int low_cnt = 0;
    bit first_seen = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_v) begin
                if (exp_q.size() == 0) check(1'b0, "R5 unexpected response", rsp_d, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rsp_d == e, "R5/R9 read data", rsp_d, e);
                end
            end
            if (rst_n && !p_rstn) check(be && p_be, "R2 reset after enable", {p_be, be}, 3);
            if (be && !p_be) check(!p_aoe && !p_doe, "R8 enable after detach", {p_aoe, p_doe}, 0);
            if ((aoe || doe) && be) check(1'b0, "R1 drive while enabled", be, 0);
            if (be) begin low_cnt = 0; first_seen = 1'b0; end
            else low_cnt++;
            if (aoe && !first_seen) begin
                first_seen = 1'b1;
                check(low_cnt > DELAY, "R4 settle delay", low_cnt - 1, DELAY);
            end
            if (p_wake) check(!irq_o, "R8 single wake pulse", irq_o, 0);
            p_wake = irq_o && !cpu_rdy;
            if (p_wake) check(be && p_be && !aoe, "R8 wake after release", {p_be, be, aoe}, 6);
            check(busy == !be, "R10 busy flag", busy, !be);
        end
        p_be = be; p_rstn = rst_n; p_aoe = aoe; p_doe = doe;
    end

    task automatic push(input logic [1:0] op, input logic [7:0] off, input logic [7:0] d);
        @(negedge clk);
        hv = 1'b1; hop = op; hoff = off; hdat = d;
        @(negedge clk);
        hv = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, input logic [7:0] e);
        exp_q.push_back(e);
        push(2'd1, off, 8'h00);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && !(be && cpu_rdy && exp_q.size() == 0); i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = 8'hEE;
        repeat (3) @(negedge clk);
        check(!be && !rst_n && busy, "R2/R10 reset state", {be, rst_n, busy}, 1);
        rst = 1'b0;

        for (int i = 0; i < 1000 && !rst_n; i++) @(negedge clk);
        check(rst_n && be, "R2 boot finished", {rst_n, be}, 3);
        begin
            int bad = 0;
            for (int k = 0; k < BOOT_LEN; k++) if (ram[k] != exp_boot(k)) bad++;
            check(bad == 0, "R2 boot image", bad, 0);
            bad = 0;
            for (int j = 0; j < 6; j++) if (ram['hFA + j] != ((j % 2) ? 8'hFF : 8'h00)) bad++;
            check(bad == 0, "R2 vectors", bad, 0);
        end

        // R7: pass-through while awake and idle
        irq_src = 1'b1;
        @(negedge clk);
        check(irq_o, "R7 irq passes when awake", irq_o, 1);
        irq_src = 1'b0;

        // R9: queue while idle, full flag, no takeover without halt
        push(2'd0, 8'h10, 8'h5A);
        push(2'd0, 8'h11, 8'hC3);
        push(2'd0, 8'h95, 8'h77);
        rd(8'h10, 8'h5A);
        rd(8'h11, 8'hC3);
        rd(8'h95, exp_boot('h95));
        rd(8'hFD, 8'hFF);
        rd(8'h00, exp_boot(0));
        check(full, "R9 queue full", full, 1);
        check(be && !busy, "R3 no takeover while ready", be, 1);

        // R3: halt, takeover next cycle
        irq_src = 1'b1;
        @(negedge clk);
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        check(be, "R3 enable still high", be, 1);
        check(!irq_o, "R7 irq masked while halted", irq_o, 0);
        @(negedge clk);
        check(!be, "R3 takeover", be, 0);
        check(!irq_o, "R7 irq masked during service", irq_o, 0);
        irq_src = 1'b0;
        for (int i = 0; i < 100 && full; i++) @(negedge clk);
        push(2'd2, 8'h00, 8'h00);
        wait_idle();
        check(ram['h95] == exp_boot('h95), "R6 protected byte intact", ram['h95], exp_boot('h95));
        check(ram['h10] == 8'h5A, "R5 write landed", ram['h10], 8'h5A);
        check(exp_q.size() == 0, "R9 all responses", exp_q.size(), 0);

        // R9: requests arriving during a transfer
        @(negedge clk);
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        repeat (2) @(negedge clk);
        push(2'd0, 8'h20, 8'h11);
        push(2'd0, 8'h20, 8'h22);
        rd(8'h20, 8'h22);
        push(2'd0, 8'hA0, 8'h33);
        rd(8'hA0, exp_boot('hA0));
        push(2'd2, 8'h00, 8'h00);
        wait_idle();
        check(be && cpu_rdy, "R8 returned to run", {be, cpu_rdy}, 3);
        check(exp_q.size() == 0, "R9 in-transfer responses", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule